// File: doc/BRIEF.md
# DDR Burst Column Address Sequencer

This block sets the order of column addresses for a single read or write burst on a double-data-rate memory. A controller drives a start strobe with a starting column. It also drives a burst length code, chosen the way a mode register would choose it, and a single select bit for sequential or interleaved order. Starting in the next cycle, the block presents one column address on every clock. With each address it raises a valid flag and a busy flag. A last-beat flag marks the final address of the burst.

The low column bits walk through an aligned block whose size equals the burst length. In sequential order the low bits count up from the start value and wrap around inside the block. In interleaved order the low bits are the start value XORed with the beat number. The column bits above the block never change during a burst. The length and the order are captured when the strobe is accepted, so a controller may change them freely while a burst is running. A new strobe given on the last beat starts the next burst with no idle cycle between them.

Top module: `burst_col_seq`

## Requirements
- R1: The 3-bit burst length code maps as follows: 3'b001 selects 2 beats, 3'b010 selects 4 beats and 3'b011 selects 8 beats. All other codes are reserved.
- R2: A strobe with a valid code, accepted while idle, makes `col_o` equal the start column in the next cycle. In that same cycle `col_vld_o` and `busy_o` go high.
- R3: With `ilv_sel_i`=0 (sequential), the low log2(length) bits of beat k equal (start + k) mod length.
- R4: With `ilv_sel_i`=1 (interleaved), the low log2(length) bits of beat k equal start XOR k.
- R5: Column bits at and above log2(length) keep their start value for every beat of the burst.
- R6: Exactly length beats are issued, one per clock, and `last_o` is high on the final beat only.
- R7: A strobe with a reserved code, seen while idle or on a last beat, starts no burst. In that case `cfg_err_o` is high for exactly the next cycle.
- R8: Changes to `bl_code_i`, `ilv_sel_i` or `start_col_i` during a burst do not alter that burst's addresses.
- R9: A strobe during any beat except the last is ignored.
- R10: A valid strobe on the last beat starts the next burst in the following cycle, with no idle cycle.
- R11: After a last beat with no strobe, `col_vld_o` and `busy_o` are low in the next cycle.
- R12: After synchronous reset, `col_vld_o`, `last_o`, `busy_o` and `cfg_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Burst start strobe |
| start_col_i | input | COL_W | Starting column address |
| bl_code_i | input | 3 | Burst length code |
| ilv_sel_i | input | 1 | Beat order: 0 sequential, 1 interleaved |
| col_o | output | COL_W | Column address of the current beat |
| col_vld_o | output | 1 | Current beat is valid |
| last_o | output | 1 | Current beat is the final one |
| busy_o | output | 1 | A burst is in progress |
| cfg_err_o | output | 1 | A strobe with a reserved code was rejected |

## Verification
The hardest situations to reach from the ports are the ones where a strobe lands on the final beat. There it may chain a new burst, or it may be rejected because its code is reserved. Configuration changes made in the middle of a burst are just as awkward to reach. To cover these, the random bursts raise the strobe and scramble the code, order and column on every non-final beat. The bench then chains bursts from the last beat, sometimes with a reserved code. Directed sweeps run every start offset under every length and both orders, with random upper column bits.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  // log2 of the longest burst (8 beats)
  localparam int LW      = 3;
  localparam int CODE_W  = 3;

  localparam logic [CODE_W-1:0] CODE_BL2 = 3'b001;
  localparam logic [CODE_W-1:0] CODE_BL4 = 3'b010;
  localparam logic [CODE_W-1:0] CODE_BL8 = 3'b011;

  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    return (c == CODE_BL2) || (c == CODE_BL4) || (c == CODE_BL8);
  endfunction

  // mask of the low bits that walk inside the aligned block
  function automatic logic [LW-1:0] code_mask(input logic [CODE_W-1:0] c);
    case (c)
      CODE_BL2: return 3'b001;
      CODE_BL4: return 3'b011;
      CODE_BL8: return 3'b111;
      default:  return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/bcs_cfg_decode.sv
module bcs_cfg_decode
  import bcs_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic              ok_o,
  output logic [LW-1:0]     mask_o
);
  always_comb begin
    ok_o   = code_ok(code_i);
    mask_o = code_mask(code_i);
  end
endmodule

// File: rtl/bcs_beat_ctr.sv
module bcs_beat_ctr
  import bcs_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic [LW-1:0] mask_nxt_i,
  output logic [LW-1:0] idx_nxt_o,
  output logic          last_nxt_o
);
  logic [LW-1:0] idx_q;

  always_comb begin
    if (load_i) idx_nxt_o = '0;
    else        idx_nxt_o = idx_q + 1'b1;
    last_nxt_o = (idx_nxt_o == mask_nxt_i);
  end

  always_ff @(posedge clk) begin
    if (rst)                 idx_q <= '0;
    else if (load_i || adv_i) idx_q <= idx_nxt_o;
  end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [LW-1:0]    idx_i,
  input  logic [LW-1:0]    mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [LW-1:0] seq_low;
  logic [LW-1:0] ilv_low;

  always_comb begin
    seq_low = base_i[LW-1:0] + idx_i;
    ilv_low = base_i[LW-1:0] ^ idx_i;
  end

  // each low bit walks only when the burst length covers it
  for (genvar b = 0; b < LW; b++) begin : g_low
    always_comb begin
      if (mask_i[b]) col_o[b] = ilv_i ? ilv_low[b] : seq_low[b];
      else           col_o[b] = base_i[b];
    end
  end

  always_comb col_o[COL_W-1:LW] = base_i[COL_W-1:LW];
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             ilv_sel_i,
  output logic [COL_W-1:0] col_o,
  output logic             col_vld_o,
  output logic             last_o,
  output logic             busy_o,
  output logic             cfg_err_o
);
  logic             dec_ok;
  logic [LW-1:0]    dec_mask;
  logic [LW-1:0]    mask_q, mask_n;
  logic             ilv_q, ilv_n;
  logic [COL_W-1:0] base_q, base_n;
  logic [LW-1:0]    idx_n;
  logic             last_n;
  logic [COL_W-1:0] col_n;
  logic             vld_q, last_q, busy_q, err_q;
  logic [COL_W-1:0] col_q;
  logic             win, go, adv;

  bcs_cfg_decode u_dec (
    .code_i (bl_code_i),
    .ok_o   (dec_ok),
    .mask_o (dec_mask)
  );

  always_comb begin
    win    = !vld_q || last_q;
    go     = start_i && win && dec_ok;
    adv    = vld_q && !last_q;
    mask_n = go ? dec_mask    : mask_q;
    ilv_n  = go ? ilv_sel_i   : ilv_q;
    base_n = go ? start_col_i : base_q;
  end

  bcs_beat_ctr u_ctr (
    .clk        (clk),
    .rst        (rst),
    .load_i     (go),
    .adv_i      (adv),
    .mask_nxt_i (mask_n),
    .idx_nxt_o  (idx_n),
    .last_nxt_o (last_n)
  );

  bcs_addr_gen #(.COL_W(COL_W)) u_gen (
    .base_i (base_n),
    .idx_i  (idx_n),
    .mask_i (mask_n),
    .ilv_i  (ilv_n),
    .col_o  (col_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      ilv_q  <= 1'b0;
      base_q <= '0;
      col_q  <= '0;
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q  <= start_i && win && !dec_ok;
      vld_q  <= go || adv;
      busy_q <= go || adv;
      if (go) begin
        mask_q <= dec_mask;
        ilv_q  <= ilv_sel_i;
        base_q <= start_col_i;
      end
      if (go || adv) begin
        col_q  <= col_n;
        last_q <= last_n;
      end else begin
        last_q <= 1'b0;
      end
    end
  end

  always_comb begin
    col_o     = col_q;
    col_vld_o = vld_q;
    last_o    = last_q;
    busy_o    = busy_q;
    cfg_err_o = err_q;
  end
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       bl_code_i,
  input logic [COL_W-1:0] col_o,
  input logic             col_vld_o,
  input logic             last_o,
  input logic             busy_o,
  input logic             cfg_err_o
);
  logic [3:0] beat_cnt;

  always_ff @(posedge clk) begin
    if (rst || !col_vld_o || last_o) beat_cnt <= '0;
    else                             beat_cnt <= beat_cnt + 1'b1;
  end

  assert_reset_R12: assert property (@(posedge clk)
    rst |=> (!col_vld_o && !last_o && !busy_o && !cfg_err_o));

  assert_first_beat_R2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !col_vld_o && code_ok(bl_code_i)) |=>
      (col_vld_o && busy_o && col_o == $past(start_col_i)));

  assert_upper_fixed_R5: assert property (@(posedge clk) disable iff (rst)
    (col_vld_o && !last_o) |=> (col_o[COL_W-1:LW] == $past(col_o[COL_W-1:LW])));

  assert_last_in_burst_R6: assert property (@(posedge clk) disable iff (rst)
    last_o |-> col_vld_o);

  assert_beat_limit_R6: assert property (@(posedge clk) disable iff (rst)
    (col_vld_o && beat_cnt == 4'd7) |-> last_o);

  assert_reserved_R7: assert property (@(posedge clk) disable iff (rst)
    (start_i && (!col_vld_o || last_o) && !code_ok(bl_code_i)) |=>
      (cfg_err_o && !col_vld_o));

  assert_mid_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (col_vld_o && !last_o) |=> (col_vld_o && !cfg_err_o));

  assert_chain_R10: assert property (@(posedge clk) disable iff (rst)
    (last_o && start_i && code_ok(bl_code_i)) |=>
      (col_vld_o && col_o == $past(start_col_i)));

  assert_idle_after_R11: assert property (@(posedge clk) disable iff (rst)
    (last_o && !start_i) |=> (!col_vld_o && !busy_o));
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_bcs_checker (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .bl_code_i   (bl_code_i),
  .col_o       (col_o),
  .col_vld_o   (col_vld_o),
  .last_o      (last_o),
  .busy_o      (busy_o),
  .cfg_err_o   (cfg_err_o)
);

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       bl_code_i = 3'b001;
  logic             ilv_sel_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             col_vld_o, last_o, busy_o, cfg_err_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u_burst_col_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .bl_code_i(bl_code_i), .ilv_sel_i(ilv_sel_i), .col_o(col_o),
    .col_vld_o(col_vld_o), .last_o(last_o), .busy_o(busy_o), .cfg_err_o(cfg_err_o)
  );

  // R1 code table
  function automatic int len_of(input logic [2:0] c);
    case (c)
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      default: return 0;
    endcase
  endfunction

  // R3 / R4 / R5 reference
  function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] sc, input int k,
                                               input int len, input logic il);
    logic [COL_W-1:0] m, low;
    m   = COL_W'(len - 1);
    low = il ? (sc ^ COL_W'(k)) : (sc + COL_W'(k));
    return (sc & ~m) | (low & m);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_start(input logic [COL_W-1:0] sc, input logic [2:0] c, input logic il);
    start_i = 1'b1; start_col_i = sc; bl_code_i = c; ilv_sel_i = il;
  endtask

  // at a negedge just after the accept edge; returns at the negedge showing the last beat
  task automatic walk(input logic [COL_W-1:0] sc, input int len, input logic il,
                      input bit disturb);
    for (int k = 0; k < len; k++) begin
      if (k > 0) @(negedge clk);
      chk(col_o == exp_col(sc, k, len, il), il ? "R4" : "R3", col_o, exp_col(sc, k, len, il));
      chk(col_vld_o && busy_o, "R6", {col_vld_o, busy_o}, 3);
      chk(last_o == (k == len - 1), "R6", last_o, k == len - 1);
      if (k < len - 1) begin
        // R8 / R9: scramble configuration and strobe mid burst
        start_i = disturb;
        if (disturb) begin
          start_col_i = COL_W'($urandom);
          bl_code_i   = 3'($urandom);
          ilv_sel_i   = 1'($urandom);
        end
      end else begin
        start_i = 1'b0;
      end
    end
  endtask

  task automatic finish_idle();
    start_i = 1'b0;
    @(negedge clk);
    chk(!col_vld_o && !busy_o && !last_o, "R11", {col_vld_o, busy_o}, 0);
    chk(!cfg_err_o, "R9", cfg_err_o, 0);
  endtask

  task automatic burst(input logic [COL_W-1:0] sc, input logic [2:0] c, input logic il,
                       input bit disturb);
    drive_start(sc, c, il);
    @(negedge clk);
    start_i = 1'b0;
    chk(col_o == sc, "R2", col_o, sc);
    walk(sc, len_of(c), il, disturb);
    finish_idle();
  endtask

  initial begin
    #(10 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!col_vld_o && !last_o && !busy_o && !cfg_err_o, "R12",
        {col_vld_o, last_o, busy_o, cfg_err_o}, 0);
    rst = 1'b0;
    @(negedge clk);

    // directed sweep: every length, order and start offset (R1, R3, R4, R5)
    for (int c = 1; c <= 3; c++)
      for (int il = 0; il < 2; il++)
        for (int s = 0; s < 8; s++)
          burst(COL_W'({$urandom} & 32'h3F8) | COL_W'(s), 3'(c), 1'(il), 1'b0);

    // reserved codes from idle (R7)
    for (int c = 0; c < 8; c++) begin
      if (len_of(3'(c)) != 0) continue;
      drive_start(COL_W'(c), 3'(c), 1'b0);
      @(negedge clk);
      start_i = 1'b0;
      chk(cfg_err_o && !col_vld_o, "R7", {cfg_err_o, col_vld_o}, 2);
      @(negedge clk);
      chk(!cfg_err_o && !col_vld_o, "R7", {cfg_err_o, col_vld_o}, 0);
    end

    // back-to-back chains from the last beat (R10), with one reserved in the chain (R7)
    begin
      logic [COL_W-1:0] a, b;
      a = 10'h2B5; b = 10'h11E;
      drive_start(a, 3'b011, 1'b1);
      @(negedge clk);
      start_i = 1'b0;
      walk(a, 8, 1'b1, 1'b1);
      drive_start(b, 3'b010, 1'b0);
      @(negedge clk);
      start_i = 1'b0;
      chk(col_vld_o && col_o == b, "R10", col_o, b);
      walk(b, 4, 1'b0, 1'b0);
      drive_start(10'h055, 3'b110, 1'b1);
      @(negedge clk);
      start_i = 1'b0;
      chk(cfg_err_o && !col_vld_o, "R7", {cfg_err_o, col_vld_o}, 2);
      @(negedge clk);
    end

    // random bursts with mid-burst disturbance and random chaining (R8, R9, R10)
    for (int i = 0; i < 300; i++) begin
      logic [COL_W-1:0] sc;
      logic [2:0] c;
      logic il;
      sc = COL_W'($urandom);
      c  = 3'(1 + ($urandom % 3));
      il = 1'($urandom);
      burst(sc, c, il, 1'b1);
      if ($urandom % 2 == 1) begin
        logic [COL_W-1:0] s2;
        logic [2:0] c2;
        s2 = COL_W'($urandom);
        c2 = 3'(1 + ($urandom % 3));
        drive_start(s2, c2, 1'b0);
        @(negedge clk);
        start_i = 1'b0;
        walk(s2, len_of(c2), 1'b0, 1'b1);
        drive_start(sc, c, il);
        @(negedge clk);
        start_i = 1'b0;
        chk(col_vld_o && col_o == sc, "R10", col_o, sc);
        walk(sc, len_of(c), il, 1'b0);
        finish_idle();
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule